// File: doc/BRIEF.md
# Timed Unlock Gate for Protected Configuration Registers

This block sits in front of a bank of protected configuration registers and decides when software may write them. The bank stays read-only until software writes two fixed key bytes, one after the other, to a write-only key address. After the second byte the gate opens for a fixed number of clock cycles and then closes again without any further action from software.

Reading the key address returns a status byte. That byte shows the sequence state, an open flag, and a coarse count of the time left in the window. A second address reads as a constant identification byte. The `wr_allow` output is high while the gate is open, and it qualifies the write enables of the protected bank.

A one-byte demonstration register is included so that the gating can be seen at the ports. Reads of it always work. Writes to it take effect only while the gate is open.

Top module: `safe_unlock`

## Requirements
- R1: After reset the gate is closed: `wr_allow` is 0, the status byte reads 0x00 and the demonstration register reads 0x00.
- R2: The sequence is a write of 0x57 to the key address (0) followed by a write of 0xA8 to the same address. In the cycle after the 0xA8 write, `wr_allow` is 1 and the status byte reads 0x7B. The status byte is laid out as follows: bits 1:0 hold the mode (2'b11 open, 2'b01 first key seen, 2'b00 idle); bit 3 is the open flag; bits 6:4 hold the timer; bits 2 and 7 read 0.
- R3: After 0x57 the mode reads 2'b01. If the next key-address write carries any value other than 0xA8, including 0x57 again, the mode returns to 2'b00 and the gate stays closed.
- R4: The gate stays open for exactly 128 cycles. In the k-th open cycle (k = 0..127), the timer field reads (127-k)/16, rounded down. In the next cycle the gate is closed and the status byte reads 0x00.
- R5: Any write to the key address while the gate is open closes it in the next cycle with the mode at 2'b00. A 0x57 written this way does not start a new sequence.
- R6: Address 1 always reads 0x04.
- R7: A write to the demonstration register (address 2) while the gate is closed is ignored. The register keeps reading its previous value.
- R8: A write to the demonstration register while the gate is open is read back from address 2 in the next cycle.
- R9: Writes to addresses other than the key address do not change the sequence state. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| wr_allow | output | 1 | High while protected registers may be written |

## Verification
Each write is registered on one clock edge, and `rd_data` is decoded combinationally from state. Every result of a write is therefore due on the first falling edge after the edge that captured the write. The bench drives one write per cycle and advances its reference model at that same rising edge. It then sweeps `rd_addr` over all four addresses within the low half of the clock and compares each read, and `wr_allow`, against the model. The 128-cycle window is stepped through cycle by cycle, so each change of the timer field and the closing cycle fall on exact, counted samples.

// File: rtl/safe_unlock.sv
module safe_unlock #(
  parameter int          WIN_UNITS = 8,
  parameter int          UNIT_CYC  = 16,
  parameter logic [7:0]  KEY_FIRST = 8'h57,
  parameter logic [7:0]  KEY_LAST  = 8'hA8,
  parameter logic [7:0]  ID_VALUE  = 8'h04,
  parameter logic [1:0]  A_KEY     = 2'd0,
  parameter logic [1:0]  A_ID      = 2'd1,
  parameter logic [1:0]  A_DEMO    = 2'd2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       wr_allow
);
  localparam int WIN   = WIN_UNITS * UNIT_CYC;
  localparam int CNT_W = $clog2(WIN);
  localparam int TMR_W = $clog2(WIN_UNITS);

  typedef enum logic [1:0] {ST_IDLE = 2'b00, ST_HALF = 2'b01, ST_OPEN = 2'b11} st_t;

  st_t              state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       demo;
  logic             key_wr;
  logic [TMR_W-1:0] tmr;
  logic [7:0]       status;

  assign key_wr   = wr_en && (wr_addr == A_KEY);
  assign wr_allow = (state == ST_OPEN);
  assign tmr      = wr_allow ? cnt[CNT_W-1 -: TMR_W] : '0;
  assign status   = {1'b0, tmr, wr_allow, 1'b0, state};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (key_wr && wr_data == KEY_FIRST) state <= ST_HALF;
        ST_HALF: if (key_wr) begin
          if (wr_data == KEY_LAST) begin
            state <= ST_OPEN;
            cnt   <= CNT_W'(WIN - 1);
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_OPEN: begin
          if (key_wr || cnt == '0) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       demo <= '0;
    else if (wr_allow && wr_en && wr_addr == A_DEMO)  demo <= wr_data;
  end

  always_comb begin
    unique case (rd_addr)
      A_KEY:   rd_data = status;
      A_ID:    rd_data = ID_VALUE;
      A_DEMO:  rd_data = demo;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/safe_unlock_chk.sv
module safe_unlock_chk #(
  parameter int         CNT_W  = 7,
  parameter logic [1:0] A_KEY  = 2'd0,
  parameter logic [1:0] A_ID   = 2'd1,
  parameter logic [1:0] A_DEMO = 2'd2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [7:0]       wr_data,
  input logic [1:0]       rd_addr,
  input logic [7:0]       rd_data,
  input logic             wr_allow,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] cnt,
  input logic [7:0]       demo
);
  assert_open_needs_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_allow) |-> $past(wr_en && wr_addr == A_KEY && wr_data == 8'hA8 && mode == 2'b01));

  assert_flag_matches_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == A_KEY |-> rd_data[3] == (rd_data[1:0] == 2'b11));

  assert_bad_second_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 && wr_en && wr_addr == A_KEY && wr_data != 8'hA8 |=> mode == 2'b00);

  assert_window_counts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_allow && !(wr_en && wr_addr == A_KEY) && cnt != '0 |=> wr_allow && cnt == $past(cnt) - 1'b1);

  assert_window_expires_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_allow && cnt == '0 |=> !wr_allow);

  assert_key_write_relocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_allow && wr_en && wr_addr == A_KEY |=> mode == 2'b00);

  assert_id_constant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == A_ID |-> rd_data == 8'h04);

  assert_locked_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_allow && wr_en && wr_addr == A_DEMO |=> $stable(demo));

  assert_open_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_allow && wr_en && wr_addr == A_DEMO |=> demo == $past(wr_data));
endmodule

bind safe_unlock safe_unlock_chk #(.CNT_W(CNT_W), .A_KEY(A_KEY), .A_ID(A_ID), .A_DEMO(A_DEMO)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .wr_allow(wr_allow),
  .mode(state), .cnt(cnt), .demo(demo)
);

// File: tb/safe_unlock_bench.sv
`timescale 1ns/100ps
module safe_unlock_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       wr_allow;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  logic [1:0] m_mode = 2'b00;
  int         m_left = 0;
  logic [7:0] m_demo = 8'h00;

  safe_unlock u_safe_unlock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_allow(wr_allow)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  function automatic logic [7:0] exp_status();
    logic [2:0] t;
    t = (m_mode == 2'b11) ? 3'(m_left / 16) : 3'd0;
    return {1'b0, t, m_mode == 2'b11, 1'b0, m_mode};
  endfunction

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return exp_status();
      2'd1: return 8'h04;
      2'd2: return m_demo;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_edge(input logic we, input logic [1:0] a, input logic [7:0] d);
    logic kw;
    kw = we && a == 2'd0;
    if (m_mode == 2'b11 && we && a == 2'd2) m_demo = d;
    case (m_mode)
      2'b00: if (kw && d == 8'h57) m_mode = 2'b01;
      2'b01: if (kw) begin
        if (d == 8'hA8) begin m_mode = 2'b11; m_left = 127; end
        else m_mode = 2'b00;
      end
      default: begin
        if (kw || m_left == 0) begin m_mode = 2'b00; m_left = 0; end
        else m_left--;
      end
    endcase
  endtask

  task automatic check_all(input string tag);
    vectors++;
    if (wr_allow !== (m_mode == 2'b11)) begin
      miscompares++;
      $display("FAIL %s wr_allow: actual %b expected %b", tag, wr_allow, m_mode == 2'b11);
    end
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #0.5;
      vectors++;
      if (rd_data !== exp_read(2'(a))) begin
        miscompares++;
        $display("FAIL %s addr %0d: actual %h expected %h", tag, a, rd_data, exp_read(2'(a)));
      end
    end
  endtask

  task automatic step(input logic we, input logic [1:0] a, input logic [7:0] d, input string tag);
    wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    model_edge(we, a, d);
    @(negedge clk);
    wr_en = 1'b0;
    check_all(tag);
  endtask

  initial begin
    logic [31:0] seed;
    seed = 32'd2024;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset");

    step(1'b1, 2'd2, 8'h11, "R7 locked demo write");
    step(1'b1, 2'd0, 8'h57, "R3 first key");
    step(1'b1, 2'd0, 8'h12, "R3 wrong second byte");
    step(1'b1, 2'd0, 8'h57, "R3 first key again");
    step(1'b1, 2'd0, 8'h57, "R3 repeated first key");
    step(1'b1, 2'd0, 8'hA8, "R3 late second byte");

    step(1'b1, 2'd0, 8'h57, "R2 first key");
    step(1'b1, 2'd2, 8'h22, "R9 demo write mid-sequence");
    step(1'b1, 2'd3, 8'h99, "R9 other write mid-sequence");
    step(1'b1, 2'd0, 8'hA8, "R2 second key");
    if (rd_data !== 8'h00 || exp_status() !== 8'h7B) begin
      miscompares++;
      $display("FAIL R2 open status: actual %h expected %h", exp_status(), 8'h7B);
    end
    vectors++;
    step(1'b1, 2'd2, 8'h3C, "R8 open demo write");
    for (int k = 0; k < 127; k++) step(1'b0, 2'd0, 8'h00, "R4 window");
    step(1'b1, 2'd2, 8'h44, "R7 write after expiry");

    step(1'b1, 2'd0, 8'h57, "R5 setup");
    step(1'b1, 2'd0, 8'hA8, "R5 open");
    step(1'b0, 2'd0, 8'h00, "R5 idle");
    step(1'b1, 2'd0, 8'h57, "R5 key write relocks");
    step(1'b1, 2'd0, 8'hA8, "R5 no new sequence");
    step(1'b1, 2'd1, 8'hFF, "R6 write to id");

    for (int i = 0; i < 4000; i++) begin
      logic [7:0] d;
      logic [1:0] a;
      logic       we;
      we = ($urandom % 4) != 0;
      a  = ($urandom % 3 == 0) ? 2'($urandom) : 2'd0;
      case ($urandom % 4)
        0: d = 8'h57;
        1: d = 8'hA8;
        default: d = 8'($urandom);
      endcase
      if (m_mode == 2'b11 && ($urandom % 8) != 0 && a == 2'd0) we = 1'b0;
      step(we, a, d, "random mix");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule